// File: doc/BRIEF.md
# Configuration Address/Data Access Port

This block gives a host processor indirect access to configuration space through two registers on a small 32-bit register bus. Software first writes a selector word that names a bus, a device, a function and a dword-aligned register, and sets an enable bit. It then reads or writes the data window to reach the selected configuration dword. Byte enables on the register bus carry 1-, 2- and 4-byte accesses. A sub-dword write lands on the lanes that match the low address bits. A read always returns the whole dword, and the requester shifts and masks out the byte or halfword it wants.

Only the bridge itself is present behind the port, at bus 0, device 0, function 0. It is a register array whose first dword is a fixed, read-only identity word. The bridge's interrupt, control and inbound-window registers (dword offsets 0x48, 0x4C and 0x50 to 0x58) are ordinary entries of this array. Any other target, and any data access with the enable bit clear, behaves as an absent device: reads return all ones and writes are dropped.

Top module: `cfgx_port`

## Requirements
- R1: After reset, rsp_valid is 0, the selector word reads back as 0x00000000, and every writable configuration dword reads back as 0.
- R2: The selector register sits at byte offset 0x28. A write updates only the byte lanes whose req_be bit is set, and a read of 0x28 returns the stored 32-bit word.
- R3: The selector word is decoded as enable = bit 31, bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2. Bits 1:0 and bits 30:24 have no effect on which dword is reached.
- R4: While selector bit 31 is 0, a read of the data window at 0x2C returns 0xFFFFFFFF and a write to it changes no configuration dword.
- R5: A data-window write with req_be = 4'b1111 to a present target replaces the whole selected dword.
- R6: A data-window write with a partial req_be changes only the enabled byte lanes of the selected dword. A 1-byte write at 0x2C+k uses req_be = 1<<k with the byte in lane k, and a 2-byte write uses req_be = 4'b0011 or 4'b1100.
- R7: Every read request gives exactly one rsp_valid pulse in the cycle after the request, carrying the full 32-bit dword. Write requests produce no rsp_valid.
- R8: When the enable bit is set but bus, device or function is nonzero, data reads return 0xFFFFFFFF and data writes are discarded.
- R9: Dword index 0 of the bridge space returns the ID_WORD parameter (default 0x0C3A1D57), and writes to it are ignored.
- R10: Reads of any control-space offset other than 0x28 and 0x2C return 0, and writes to such offsets change neither the selector nor configuration space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register-bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address within the control space |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data, lane-aligned |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |

## Verification
All state updates land on the clock edge that samples the request. A read of the selector or of configuration space therefore already shows a write made in the cycle before. Read data is registered once, so rsp_valid and rsp_rdata are due exactly one cycle after the read request. The bench drives every request on the falling edge and samples the response on the next falling edge, which is one register stage after the capturing edge. It also checks that rsp_valid is low after each write.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int DW      = 32;
    localparam int LANES   = DW / 8;
    localparam int IDX_W   = 6;

    typedef struct packed {
        logic             en;
        logic [7:0]       bus;
        logic [4:0]       dev;
        logic [2:0]       fn;
        logic [IDX_W-1:0] idx;
    } cfgx_sel_t;

    typedef struct packed {
        logic          rsp_valid;
        logic [DW-1:0] rsp_data;
    } cfgx_rsp_t;

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] new_w,
                                                  input logic [LANES-1:0] be);
        logic [DW-1:0] r;
        r = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[i*8 +: 8] = new_w[i*8 +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  be,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     word,
    output cfgx_sel_t         sel
);

    logic [DW-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (wr_en) word_d = lane_merge(word_q, wdata, be);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word    = word_q;
    assign sel.en  = word_q[31];
    assign sel.bus = word_q[23:16];
    assign sel.dev = word_q[15:11];
    assign sel.fn  = word_q[10:8];
    assign sel.idx = word_q[7:2];

    // a full-lane selector write is visible on the next cycle
    assert_sel_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == '1) |=> (word == $past(wdata)));

endmodule

// File: rtl/cfgx_space.sv
module cfgx_space
    import cfgx_pkg::*;
#(
    parameter int          NREGS   = 64,
    parameter logic [31:0] ID_WORD = 32'h0C3A_1D57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  be,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata
);

    localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [DW-1:0] mem_d [NREGS];
    logic [DW-1:0] mem_q [NREGS];
    logic          in_range;

    assign in_range = (int'(idx) < NREGS);

    always_comb begin
        for (int i = 0; i < NREGS; i++) mem_d[i] = mem_q[i];
        if (wr_en && in_range && idx != '0)
            mem_d[idx[IW-1:0]] = lane_merge(mem_q[idx[IW-1:0]], wdata, be);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) mem_q[i] <= mem_d[i];
        end
    end

    always_comb begin
        if (idx == '0)     rdata = ID_WORD;
        else if (in_range) rdata = mem_q[idx[IW-1:0]];
        else               rdata = '0;
    end

    // full-dword writes replace the addressed entry
    assert_full_dword_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be == '1 && idx != '0 && in_range)
        |=> (mem_q[$past(idx[IW-1:0])] == $past(wdata)));

endmodule

// File: rtl/cfgx_port.sv
module cfgx_port
    import cfgx_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] SEL_OFS  = 8'h28,
    parameter logic [ADDR_W-1:0] DATA_OFS = 8'h2C,
    parameter int                NREGS    = 64,
    parameter logic [31:0]       ID_WORD  = 32'h0C3A_1D57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);

    localparam int WA = ADDR_W - 2;

    logic          at_sel, at_data, hit;
    logic          sel_wr, space_wr;
    logic [DW-1:0] sel_word, space_rdata;
    cfgx_sel_t     sel;
    cfgx_rsp_t     rsp_d, rsp_q;

    assign at_sel   = (req_addr[ADDR_W-1:2] == SEL_OFS[ADDR_W-1:2]);
    assign at_data  = (req_addr[ADDR_W-1:2] == DATA_OFS[ADDR_W-1:2]);
    assign sel_wr   = req_valid && req_write && at_sel;

    cfgx_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel_wr),
        .be    (req_be),
        .wdata (req_wdata),
        .word  (sel_word),
        .sel   (sel)
    );

    assign hit      = sel.en && sel.bus == '0 && sel.dev == '0 && sel.fn == '0;
    assign space_wr = req_valid && req_write && at_data && hit;

    cfgx_space #(.NREGS(NREGS), .ID_WORD(ID_WORD)) u_space (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (space_wr),
        .idx   (sel.idx),
        .be    (req_be),
        .wdata (req_wdata),
        .rdata (space_rdata)
    );

    always_comb begin
        rsp_d.rsp_valid = req_valid && !req_write;
        rsp_d.rsp_data  = '0;
        if (req_valid && !req_write) begin
            if (at_sel)       rsp_d.rsp_data = sel_word;
            else if (at_data) rsp_d.rsp_data = hit ? space_rdata : '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.rsp_valid;
    assign rsp_rdata = rsp_q.rsp_data;

    // every response belongs to a read in the previous cycle
    assert_rsp_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // a read request always yields a response next cycle
    assert_read_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // disabled selector reads as absent
    assert_disabled_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && at_data && !sel.en) |=> (rsp_rdata == '1));

    // nonzero bus/device/function reads as absent
    assert_absent_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && at_data && sel.en &&
         (sel.bus != '0 || sel.dev != '0 || sel.fn != '0)) |=> (rsp_rdata == '1));

    // other offsets never leak data
    assert_other_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !at_sel && !at_data) |=> (rsp_rdata == '0));

endmodule

// File: tb/cfgx_port_test.sv
module cfgx_port_test;

    localparam logic [31:0] ID = 32'h0C3A_1D57;
    localparam logic [7:0]  SA = 8'h28;
    localparam logic [7:0]  DA = 8'h2C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [31:0] m_sel;
    logic [31:0] m_mem [64];

    always #5 clk = ~clk;

    cfgx_port uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
        return r;
    endfunction

    function automatic bit m_hit();
        return m_sel[31] && m_sel[23:8] == 16'h0;
    endfunction

    function automatic logic [31:0] exp_data();
        if (!m_hit())             return 32'hFFFF_FFFF;
        if (m_sel[7:2] == 6'd0)   return ID;
        return m_mem[m_sel[7:2]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
        if (a[7:2] == SA[7:2]) m_sel = merge(m_sel, d, be);
        else if (a[7:2] == DA[7:2] && m_hit() && m_sel[7:2] != 6'd0)
            m_mem[m_sel[7:2]] = merge(m_mem[m_sel[7:2]], d, be);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R7 no response to write", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic rd(input logic [7:0] a, input string req, output logic [31:0] got);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = 4'h0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 rsp_valid after read", {31'd0, rsp_valid}, 32'd1);
        got = rsp_rdata;
        if (a[7:2] == SA[7:2])      check(req, got, m_sel);
        else if (a[7:2] == DA[7:2]) check(req, got, exp_data());
        else                        check(req, got, 32'h0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] g;
        m_sel = '0;
        for (int i = 0; i < 64; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        rd(SA, "R1 selector reset value", g);
        wr(SA, 32'h8000_0048, 4'hF);
        rd(DA, "R1 config dword reset value", g);

        // R2 partial selector write
        wr(SA, 32'hAABB_CCDD, 4'b0101);
        rd(SA, "R2 selector lane write", g);
        // R4 enable clear
        wr(SA, 32'h0000_0050, 4'hF);
        rd(DA, "R4 disabled read all ones", g);
        wr(DA, 32'h1234_5678, 4'hF);
        wr(SA, 32'h8000_0050, 4'hF);
        rd(DA, "R4 disabled write discarded", g);
        // R5 full write, R3 low bits ignored and bits 30:24 ignored
        wr(DA, 32'hDEAD_BEEF, 4'hF);
        wr(SA, 32'hFF00_0053, 4'hF);
        rd(DA, "R3 low and upper bits ignored", g);
        check("R5 full dword write", g, 32'hDEAD_BEEF);
        // R6 byte write lane 2 and halfword high
        wr(DA, 32'h0099_0000, 4'b0100);
        rd(DA, "R6 byte lane write", g);
        check("R6 shifted byte extract", (g >> 16) & 32'hFF, 32'h99);
        wr(DA, 32'h5A5A_0000, 4'b1100);
        rd(DA, "R6 halfword lane write", g);
        check("R6 shifted halfword extract", (g >> 16) & 32'hFFFF, 32'h5A5A);
        // R3/R8 nonzero device, function, bus
        wr(SA, 32'h8000_0850, 4'hF);
        rd(DA, "R8 device 1 all ones", g);
        wr(DA, 32'h0, 4'hF);
        wr(SA, 32'h8000_0150, 4'hF);
        rd(DA, "R8 function 1 all ones", g);
        wr(SA, 32'h8001_0050, 4'hF);
        rd(DA, "R8 bus 1 all ones", g);
        wr(SA, 32'h8000_0050, 4'hF);
        rd(DA, "R8 absent write discarded", g);
        // R9 identity word read-only
        wr(SA, 32'h8000_0000, 4'hF);
        rd(DA, "R9 identity word", g);
        wr(DA, 32'h0, 4'hF);
        rd(DA, "R9 identity read-only", g);
        // R10 other offsets
        wr(8'h10, 32'hFFFF_FFFF, 4'hF);
        rd(8'h10, "R10 other offset reads zero", g);
        rd(SA, "R10 selector untouched", g);
        // bridge control dwords 0x48..0x58
        for (int k = 0; k < 5; k++) begin
            wr(SA, 32'h8000_0048 + 32'(k * 4), 4'hF);
            wr(DA, 32'hC0DE_0000 | 32'(k), 4'hF);
        end
        for (int k = 0; k < 5; k++) begin
            wr(SA, 32'h8000_0048 + 32'(k * 4), 4'hF);
            rd(DA, "R5 bridge control dword", g);
        end

        // constrained random
        void'($urandom(32'd20240611));
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [31:0] s, d;
            logic [3:0] be;
            op = $urandom_range(0, 9);
            d  = $urandom();
            case ($urandom_range(0, 2))
                0:       be = 4'hF;
                1:       be = 4'b0001 << $urandom_range(0, 3);
                default: be = $urandom_range(0, 1) ? 4'b1100 : 4'b0011;
            endcase
            if (op < 2) begin
                s = {($urandom_range(0, 6) != 0), 7'($urandom()),
                     ($urandom_range(0, 3) == 0) ? 16'($urandom()) : 16'h0,
                     8'($urandom())};
                wr(SA, s, 4'hF);
            end else if (op < 5) wr(DA, d, be);
            else if (op < 8)     rd(DA, "R5 R6 random data read", g);
            else if (op < 9)     rd(SA, "R2 random selector read", g);
            else                 rd({$urandom_range(0, 9) != 0 ? 8'h30 : 8'h04}, "R10 random other read", g);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule